// File: doc/BRIEF.md
# Repeated Byte Move Engine

This block carries out a block copy that a single two-byte repeat-move command starts. Three architectural registers come with the command and have no operand fields: a source pointer, a destination pointer and an element count. The engine copies one byte at a time. For each byte it reads from the source address and then writes that byte to the destination address. After every write it steps both pointers up by one and the count down by one. It stops when the count reaches zero.

A decoder feeds command bytes in one at a time. The engine watches this byte stream for the repeat prefix followed by the move opcode. When it accepts the pair, it loads the three registers from its initial-value inputs and drives a single-port memory with separate read and write strobes. The register values show on the outputs at all times. The caller therefore sees the final pointers and the zero count once the one-cycle done pulse arrives.

Top module: `strmove_engine`

## Requirements
- R1: While reset is asserted and immediately after it, the block is idle: both memory strobes, busy and done are low, and all three register outputs are zero.
- R2: A copy starts at the clock edge where cmd_valid is high with byte 0xA4, provided the previous byte accepted with cmd_valid high was 0xF2 and the engine is idle. Any other valid byte in between cancels the pending prefix. Cycles with cmd_valid low do not cancel it. A repeated 0xF2 keeps it pending.
- R3: At the start edge the pointer and count registers take the values of init_src, init_dst and init_cnt.
- R4: Each element takes a read cycle and then a write cycle. The read cycle has mem_rd high with mem_addr equal to the source pointer. The write cycle has mem_wr high with mem_addr equal to the destination pointer and mem_wdata equal to the mem_rdata returned one cycle after the read. Bytes are copied in ascending address order, so overlapping regions copy forward.
- R5: After each write cycle the source and destination pointers each rise by one, wrapping modulo 2^ADDR_W, and the count falls by one.
- R6: mem_rd and mem_wr are never high together, and neither is high while busy is low.
- R7: Busy is high from the cycle after the start edge through the last write cycle. Done is high for exactly the one cycle that follows the last write, with busy low and the count at zero.
- R8: A start with a count of zero makes no memory access and never raises busy. Done is high in the cycle right after the start edge.
- R9: While idle and not starting, the three register outputs keep their values.
- R10: Command bytes arriving while busy are discarded. A complete pair does not start a new copy, and a prefix byte seen while busy does not stay pending after the copy ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte qualifier |
| cmd_byte | input | 8 | Command byte from the decoder |
| init_src | input | ADDR_W | Source pointer value loaded at start |
| init_dst | input | ADDR_W | Destination pointer value loaded at start |
| init_cnt | input | CNT_W | Element count loaded at start |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Read strobe; data returns the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | ELEM_W | Write data |
| mem_rdata | input | ELEM_W | Read data, one cycle after mem_rd |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| src_ptr | output | ADDR_W | Current source pointer |
| dst_ptr | output | ADDR_W | Current destination pointer |
| count | output | CNT_W | Remaining element count |

## Verification
The assertions check on every cycle that the strobes are mutually exclusive and only active while busy, and that every read is followed by a write. They also check that each write steps the pointers and count by exactly one, that the registers hold in every other busy or idle cycle, that done is a single pulse with a zero count, and that a zero-count start goes straight to done. Other properties depend on the data and the byte stream, and only the bench's scenarios can show them. These are the prefix arming and cancelling rules, the discarding of a pair sent mid-copy, the forward semantics of an overlapping copy, wraparound at the top of the address space, and the final memory contents.

// File: rtl/strmove_pkg.sv
`timescale 1ns/1ps
package strmove_pkg;
  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] REP_PREFIX = 8'hF2;
  localparam logic [CODE_W-1:0] MOVE_OPCODE = 8'hA4;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/strmove_cmd_detect.sv
`timescale 1ns/1ps
module strmove_cmd_detect import strmove_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [CODE_W-1:0] byte_val,
  input  logic              engine_busy,
  output logic              start_o
);
  logic prefix_armed_q;

  // Bytes are dropped while a copy runs; a prefix then never survives it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prefix_armed_q <= 1'b0;
    end else if (engine_busy) begin
      prefix_armed_q <= 1'b0;
    end else if (byte_valid) begin
      prefix_armed_q <= (byte_val == REP_PREFIX);
    end
  end

  assign start_o = !engine_busy && byte_valid && prefix_armed_q &&
                   (byte_val == MOVE_OPCODE);
endmodule

// File: rtl/strmove_arch_regs.sv
`timescale 1ns/1ps
module strmove_arch_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_src,
  input  logic [ADDR_W-1:0] load_dst,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              advance,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              last_elem
);
  function automatic logic [ADDR_W-1:0] ptr_step(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      src_q <= load_src;
      dst_q <= load_dst;
      cnt_q <= load_cnt;
    end else if (advance) begin
      src_q <= ptr_step(src_q);
      dst_q <= ptr_step(dst_q);
      cnt_q <= cnt_step(cnt_q);
    end
  end

  assign last_elem = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/strmove_seq.sv
`timescale 1ns/1ps
module strmove_seq import strmove_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_zero,
  input  logic last_elem,
  output logic rd_en,
  output logic wr_en,
  output logic busy_o,
  output logic done_o
);
  seq_state_e state_q, state_d;
  logic       done_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          if (start_zero) done_d  = 1'b1;
          else            state_d = SEQ_READ;
        end
      end
      SEQ_READ:  state_d = SEQ_WRITE;
      SEQ_WRITE: begin
        if (last_elem) begin
          state_d = SEQ_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = SEQ_READ;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
    end
  end

  assign rd_en  = (state_q == SEQ_READ);
  assign wr_en  = (state_q == SEQ_WRITE);
  assign busy_o = (state_q != SEQ_IDLE);
endmodule

// File: rtl/strmove_engine.sv
`timescale 1ns/1ps
module strmove_engine import strmove_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int ELEM_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_byte,
  input  logic [ADDR_W-1:0] init_src,
  input  logic [ADDR_W-1:0] init_dst,
  input  logic [CNT_W-1:0]  init_cnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ELEM_W-1:0] mem_wdata,
  input  logic [ELEM_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic [CNT_W-1:0]  count
);
  // Named internal events, also used by the bound checker.
  logic start_evt;
  logic step_evt;
  logic last_elem;
  logic rd_en;
  logic wr_en;

  strmove_cmd_detect u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_valid  (cmd_valid),
    .byte_val    (cmd_byte),
    .engine_busy (busy),
    .start_o     (start_evt)
  );

  strmove_arch_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_evt),
    .load_src  (init_src),
    .load_dst  (init_dst),
    .load_cnt  (init_cnt),
    .advance   (step_evt),
    .src_q     (src_ptr),
    .dst_q     (dst_ptr),
    .cnt_q     (count),
    .last_elem (last_elem)
  );

  strmove_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_evt),
    .start_zero (init_cnt == '0),
    .last_elem  (last_elem),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .busy_o     (busy),
    .done_o     (done)
  );

  assign step_evt  = wr_en;
  assign mem_rd    = rd_en;
  assign mem_wr    = wr_en;
  assign mem_addr  = wr_en ? dst_ptr : src_ptr;
  assign mem_wdata = wr_en ? mem_rdata : '0;
endmodule

// File: rtl/strmove_engine_chk.sv
`timescale 1ns/1ps
module strmove_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
)(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] src_ptr,
  input logic [ADDR_W-1:0] dst_ptr,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  init_cnt,
  input logic              start_evt,
  input logic              step_evt
);
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_strobe_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> busy);

  p_read_then_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr);

  p_step_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (src_ptr == ADDR_W'($past(src_ptr) + 1'b1)) &&
                 (dst_ptr == ADDR_W'($past(dst_ptr) + 1'b1)));

  p_step_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> count == CNT_W'($past(count) - 1'b1));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_evt) |=> !done);

  p_done_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (count == '0) && !busy);

  p_zero_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && init_cnt == '0) |=> done && !busy);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_evt) |=> $stable(src_ptr) && $stable(dst_ptr) && $stable(count));

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_evt) |=> $stable(src_ptr) && $stable(dst_ptr) && $stable(count));
endmodule

bind strmove_engine strmove_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_strmove_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .busy      (busy),
  .done      (done),
  .src_ptr   (src_ptr),
  .dst_ptr   (dst_ptr),
  .count     (count),
  .init_cnt  (init_cnt),
  .start_evt (start_evt),
  .step_evt  (step_evt)
);

// File: tb/test_strmove_engine.sv
`timescale 1ns/1ps
module test_strmove_engine;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int MW = 11;             // bench memory mirrors the low address bits
  localparam int MSZ = 1 << MW;

  typedef struct packed {
    logic [1:0]  kind;                // 0 read, 1 write, 2 done
    logic        zero;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [15:0] src;
    logic [15:0] dst;
    logic [15:0] cnt;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [AW-1:0] init_src = '0, init_dst = '0;
  logic [CW-1:0] init_cnt = '0;
  logic [AW-1:0] mem_addr, src_ptr, dst_ptr;
  logic mem_rd, mem_wr, busy, done;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic [CW-1:0] count;

  always #2.5 clk = ~clk;

  strmove_engine #(.ADDR_W(AW), .CNT_W(CW), .ELEM_W(8)) i_strmove_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .init_src(init_src), .init_dst(init_dst), .init_cnt(init_cnt),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count(count)
  );

  logic [7:0] dut_mem [0:MSZ-1];
  logic [7:0] ref_mem [0:MSZ-1];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= dut_mem[mem_addr[MW-1:0]];
    if (mem_wr) dut_mem[mem_addr[MW-1:0]] <= mem_wdata;
  end

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  exp_t exp_q[$];
  bit last_busy = 1'b0;
  bit m_armed = 1'b0;
  logic [15:0] h_src = '0, h_dst = '0, h_cnt = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference: forward byte copy, one read and one write cycle per element.
  task automatic push_copy(input logic [15:0] s, input logic [15:0] d, input logic [15:0] n);
    exp_t e;
    for (int i = 0; i < int'(n); i++) begin
      logic [15:0] sa = s + 16'(i);
      logic [15:0] da = d + 16'(i);
      logic [7:0] v = ref_mem[sa[MW-1:0]];
      ref_mem[da[MW-1:0]] = v;
      e = '{kind: 2'd0, zero: 1'b0, addr: sa, data: 8'h00, src: sa, dst: da, cnt: n - 16'(i)};
      exp_q.push_back(e);
      e.kind = 2'd1; e.addr = da; e.data = v;
      exp_q.push_back(e);
    end
    e = '{kind: 2'd2, zero: (n == 0), addr: 16'h0, data: 8'h00,
          src: s + n, dst: d + n, cnt: 16'h0};
    exp_q.push_back(e);
  endtask

  task automatic model_edge(input bit v, input logic [7:0] b);
    if (last_busy) m_armed = 1'b0;
    else if (v) begin
      if (b == 8'hA4 && m_armed) begin
        push_copy(init_src, init_dst, init_cnt);
        m_armed = 1'b0;
      end else begin
        m_armed = (b == 8'hF2);
      end
    end
  endtask

  task automatic cyc(input bit v, input logic [7:0] b);
    cmd_valid = v;
    cmd_byte = b;
    @(posedge clk);
    model_edge(v, b);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00);
  endtask

  task automatic set_regs(input logic [15:0] s, input logic [15:0] d, input logic [15:0] n);
    init_src = s; init_dst = d; init_cnt = n;
  endtask

  // Per-cycle comparison against the reference queue, away from the clock edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      exp_t e;
      bit e_rd, e_wr, e_busy, e_done;
      string ts, tr;
      e_rd = 0; e_wr = 0; e_busy = 0; e_done = 0;
      ts = "R6"; tr = "R9";
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        case (e.kind)
          2'd0: begin e_rd = 1; e_busy = 1; ts = "R4"; tr = "R3/R5"; end
          2'd1: begin e_wr = 1; e_busy = 1; ts = "R4"; tr = "R5"; end
          default: begin
            e_done = 1; ts = e.zero ? "R8" : "R7"; tr = e.zero ? "R8" : "R7";
            h_src = e.src; h_dst = e.dst; h_cnt = e.cnt;
          end
        endcase
      end else begin
        e = '{kind: 2'd3, zero: 1'b0, addr: 16'h0, data: 8'h0, src: h_src, dst: h_dst, cnt: h_cnt};
      end
      last_busy = e_busy;
      chk(mem_rd == e_rd, ts, mem_rd, e_rd);
      chk(mem_wr == e_wr, ts, mem_wr, e_wr);
      chk(busy == e_busy, "R7", busy, e_busy);
      chk(done == e_done, ts, done, e_done);
      if (e_rd || e_wr) chk(mem_addr == e.addr, "R4", mem_addr, e.addr);
      if (e_wr) chk(mem_wdata == e.data, "R4", mem_wdata, e.data);
      chk(src_ptr == e.src, tr, src_ptr, e.src);
      chk(dst_ptr == e.dst, tr, dst_ptr, e.dst);
      chk(count == e.cnt, tr, count, e.cnt);
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 50000 && !finished) begin
      finished = 1'b1;
      n_err++;
      $display("FAIL R7: watchdog expired, actual busy %0d expected 0", busy);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MSZ; i++) begin
      dut_mem[i] = 8'((i * 7 + 3) & 255);
      ref_mem[i] = 8'((i * 7 + 3) & 255);
    end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(!mem_rd && !mem_wr && !busy && !done, "R1", {mem_rd, mem_wr, busy, done}, 0);
    chk(src_ptr == 0 && dst_ptr == 0 && count == 0, "R1", {src_ptr, count}, 0);
    rst_n = 1'b1;
    idle(2);

    // R3 R4 R5 R7: plain copy of five bytes
    set_regs(16'h0100, 16'h0200, 16'd5);
    cyc(1, 8'hF2); cyc(1, 8'hA4);
    chk(busy == 1'b1, "R2", busy, 1);
    idle(14);

    // R8: zero count
    set_regs(16'h0123, 16'h0456, 16'd0);
    cyc(1, 8'hF2); cyc(1, 8'hA4);
    chk(done == 1'b1 && busy == 1'b0, "R8", {done, busy}, 2'b10);
    idle(3);

    // R2: an unrelated byte between prefix and opcode cancels
    set_regs(16'h0300, 16'h0380, 16'd3);
    cyc(1, 8'hF2); cyc(1, 8'h00); cyc(1, 8'hA4); idle(1);
    chk(busy == 1'b0 && src_ptr == 16'h0123, "R2", src_ptr, 16'h0123);

    // R2: gap cycles keep the prefix, a repeated prefix stays pending
    cyc(1, 8'hF2); cyc(0, 8'hA4); cyc(1, 8'hF2); cyc(1, 8'hA4);
    chk(busy == 1'b1, "R2", busy, 1);
    idle(10);

    // R10: pair and lone prefix during a copy are discarded
    set_regs(16'h0500, 16'h0600, 16'd4);
    cyc(1, 8'hF2); cyc(1, 8'hA4);
    set_regs(16'h0700, 16'h0780, 16'd2);
    cyc(1, 8'hF2); cyc(1, 8'hA4); cyc(1, 8'hF2);
    idle(8);
    cyc(1, 8'hA4); idle(3);
    chk(src_ptr == 16'h0504 && count == 0, "R10", src_ptr, 16'h0504);

    // R4: overlapping forward copy
    set_regs(16'h0010, 16'h0011, 16'd6);
    cyc(1, 8'hF2); cyc(1, 8'hA4); idle(16);

    // R5: pointer wraparound
    set_regs(16'hFFFE, 16'h0040, 16'd4);
    cyc(1, 8'hF2); cyc(1, 8'hA4); idle(12);
    chk(src_ptr == 16'h0002 && dst_ptr == 16'h0044, "R5", src_ptr, 16'h0002);

    // longer copy, then R9 hold over idle cycles
    set_regs(16'h0080, 16'h0680, 16'd40);
    cyc(1, 8'hF2); cyc(1, 8'hA4); idle(90);
    chk(count == 0 && dst_ptr == 16'h06A8, "R9", dst_ptr, 16'h06A8);

    begin
      int mism = 0;
      for (int i = 0; i < MSZ; i++) if (dut_mem[i] !== ref_mem[i]) mism++;
      chk(mism == 0, "R4", mism, 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule